// File: doc/BRIEF.md
# Pipelined Carry-Save Summation Tree

This block adds N signed words that arrive together in one cycle, such as the tap products of a fully parallel FIR, and produces their total. The reduction is built from 3:2 carry-save compressors. Each one turns three operands into a sum word and a carry word without rippling carries. Every level of compressors ends in a register, so no combinational path covers more than one level. Operands that do not fill a group of three at some level are registered and passed on unchanged. When two words remain, one carry-propagate adder forms the result, and that adder is a registered stage of its own.

Inputs are sign-extended by ceil(log2 N) bits before compression, so no intermediate or final value can overflow. The tree accepts a new operand set on every clock. The valid flag runs through a shift register exactly as long as the data path, so result and valid leave together. The latency is derived from N. With the default of eight operands there are four compression levels and one adder stage, five registers in all. Stage registers load only when the valid bit that reaches them is high, so idle cycles leave the pipeline contents unchanged.

Top module: `csat_tree`

## Requirements
- R1: `out_sum` equals the two's-complement sum of the N signed W-bit lanes of `in_ops` (lane i at bits i*W..i*W+W-1), expressed in SW = W + ceil(log2 N) bits.
- R2: Every compression level keeps the arithmetic total of its operand words, modulo 2^SW, from its inputs to its registered outputs.
- R3: Extreme inputs do not overflow: with N=8, W=16, all lanes at -32768 give -262144 and all lanes at 32767 give 262136.
- R4: While no valid set reaches the adder stage, `out_sum` keeps its last value, whatever `in_ops` carries while `in_vld` is low.
- R5: `out_vld` is `in_vld` delayed by exactly LAT = levels + 1 register stages (LAT = 5 for N=8). Each valid set yields exactly one valid result, and `out_sum` is aligned with it.
- R6: Operands left over at a level (with N=8, lanes 6 and 7 at the first level) reach the result unchanged, so a value on those lanes alone appears as the result.
- R7: A new operand set is accepted on every clock, and back-to-back valid sets produce results on consecutive cycles in order.
- R8: While `rst_n` is low, `out_vld` is 0 and `out_sum` is 0, including when the reset is asserted with sets still in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Operand set on `in_ops` is valid this cycle |
| in_ops | input | N*W | N signed operand lanes, lane i at bits i*W upward |
| out_vld | output | 1 | `out_sum` holds a new result |
| out_sum | output | W+ceil(log2 N) | Registered signed total |

## Verification
The bench feeds all lanes at the most negative value and then at the most positive value. A tree that dropped the sign extension or the width growth would return a wrapped total there. A value placed only on the lanes that bypass the first compressor group checks the leftover path. A broken pass-through shows up as a missing or doubled contribution. Back-to-back sets with a valid-delay check on every cycle catch a valid chain one stage short or long, and idle cycles with noisy inputs catch an output register that loads without a valid. An asynchronous reset in the middle of a burst must clear the output at once, before the next edge.

// File: rtl/csat_pkg.sv
package csat_pkg;

  // Operand count after one 3:2 level: each full triple becomes two words,
  // leftovers pass through.
  function automatic int csat_next(input int n);
    return 2 * (n / 3) + (n % 3);
  endfunction

  // Number of compression levels until at most two words remain.
  function automatic int csat_levels(input int n);
    int c;
    int k;
    c = n;
    k = 0;
    for (int i = 0; i < 64; i++) begin
      if (c > 2) begin
        c = csat_next(c);
        k = k + 1;
      end
    end
    return k;
  endfunction

  // Operand count entering a given level.
  function automatic int csat_count(input int n, input int lvl);
    int c;
    c = n;
    for (int i = 0; i < 64; i++) begin
      if (i < lvl) c = csat_next(c);
    end
    return c;
  endfunction

endpackage

// File: rtl/csat_compress.sv
module csat_compress #(
  parameter int SW = 19
) (
  input  logic [SW-1:0] op_a,
  input  logic [SW-1:0] op_b,
  input  logic [SW-1:0] op_c,
  output logic [SW-1:0] sum_w,
  output logic [SW-1:0] cry_w
);
  logic [SW-1:0] maj;

  always_comb begin
    sum_w = op_a ^ op_b ^ op_c;
    maj   = (op_a & op_b) | (op_a & op_c) | (op_b & op_c);
    cry_w = {maj[SW-2:0], 1'b0};
  end
endmodule

// File: rtl/csat_level.sv
module csat_level #(
  parameter int SW     = 19,
  parameter int IN_CNT = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en,
  input  logic [IN_CNT*SW-1:0]        in_ops,
  output logic [(2*(IN_CNT/3)+(IN_CNT%3))*SW-1:0] out_ops
);
  localparam int GROUPS  = IN_CNT / 3;
  localparam int REST    = IN_CNT % 3;
  localparam int OUT_CNT = 2 * GROUPS + REST;

  logic [OUT_CNT*SW-1:0] nxt_ops;

  for (genvar g = 0; g < GROUPS; g++) begin : g_cmp
    csat_compress #(.SW(SW)) u_cmp (
      .op_a  (in_ops[(3*g)*SW   +: SW]),
      .op_b  (in_ops[(3*g+1)*SW +: SW]),
      .op_c  (in_ops[(3*g+2)*SW +: SW]),
      .sum_w (nxt_ops[(2*g)*SW   +: SW]),
      .cry_w (nxt_ops[(2*g+1)*SW +: SW])
    );
  end

  for (genvar r = 0; r < REST; r++) begin : g_pass
    assign nxt_ops[(2*GROUPS+r)*SW +: SW] = in_ops[(3*GROUPS+r)*SW +: SW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  out_ops <= '0;
    else if (en) out_ops <= nxt_ops;
  end

  // Totals of the words on both sides, for the conservation check.
  logic [SW-1:0] in_total;
  logic [SW-1:0] out_total;
  always_comb begin
    in_total = '0;
    for (int i = 0; i < IN_CNT; i++) in_total = in_total + in_ops[i*SW +: SW];
    out_total = '0;
    for (int i = 0; i < OUT_CNT; i++) out_total = out_total + out_ops[i*SW +: SW];
  end

  p_sum_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (out_total == $past(in_total)));

  if (REST > 0) begin : g_rest_chk
    p_rest_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (out_ops[(OUT_CNT-1)*SW +: SW] == $past(in_ops[(IN_CNT-1)*SW +: SW])));
  end
endmodule

// File: rtl/csat_cpa.sv
module csat_cpa #(
  parameter int SW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [SW-1:0] word_a,
  input  logic [SW-1:0] word_b,
  output logic [SW-1:0] total
);
  logic [SW-1:0] nxt_total;

  always_comb nxt_total = word_a + word_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  total <= '0;
    else if (en) total <= nxt_total;
  end

  p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(total));
endmodule

// File: rtl/csat_vpipe.sv
module csat_vpipe #(
  parameter int LAT = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           vld_in,
  output logic [LAT-1:0] stage_vld
);
  logic [LAT-1:0] nxt_vld;

  always_comb begin
    nxt_vld[0] = vld_in;
    for (int i = 1; i < LAT; i++) nxt_vld[i] = stage_vld[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_vld <= '0;
    else        stage_vld <= nxt_vld;
  end
endmodule

// File: rtl/csat_tree.sv
module csat_tree
  import csat_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_vld,
  input  logic [N*W-1:0]            in_ops,
  output logic                      out_vld,
  output logic [W+$clog2(N)-1:0]    out_sum
);
  localparam int GROW = $clog2(N);
  localparam int SW   = W + GROW;
  localparam int NLVL = csat_levels(N);
  localparam int LAT  = NLVL + 1;

  logic [N*SW-1:0] ext_ops;
  logic [LAT-1:0]  stage_vld;
  logic [SW-1:0]   fin_a;
  logic [SW-1:0]   fin_b;
  logic            fin_en;

  // Sign extension of every lane to the internal width.
  for (genvar i = 0; i < N; i++) begin : g_ext
    assign ext_ops[i*SW +: SW] = {{GROW{in_ops[i*W+W-1]}}, in_ops[i*W +: W]};
  end

  csat_vpipe #(.LAT(LAT)) u_vpipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .vld_in    (in_vld),
    .stage_vld (stage_vld)
  );

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    localparam int IC = csat_count(N, l);
    localparam int OC = csat_count(N, l + 1);
    logic [IC*SW-1:0] lv_in;
    logic [OC*SW-1:0] lv_out;
    logic             lv_en;
    if (l == 0) begin : g_first
      assign lv_in = ext_ops;
      assign lv_en = in_vld;
    end else begin : g_next
      assign lv_in = g_lvl[l-1].lv_out;
      assign lv_en = stage_vld[l-1];
    end
    csat_level #(.SW(SW), .IN_CNT(IC)) u_level (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (lv_en),
      .in_ops  (lv_in),
      .out_ops (lv_out)
    );
  end

  if (NLVL == 0) begin : g_fin_direct
    assign fin_a  = ext_ops[0  +: SW];
    assign fin_b  = ext_ops[SW +: SW];
    assign fin_en = in_vld;
  end else begin : g_fin_tree
    assign fin_a  = g_lvl[NLVL-1].lv_out[0  +: SW];
    assign fin_b  = g_lvl[NLVL-1].lv_out[SW +: SW];
    assign fin_en = stage_vld[LAT-2];
  end

  csat_cpa #(.SW(SW)) u_cpa (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (fin_en),
    .word_a (fin_a),
    .word_b (fin_b),
    .total  (out_sum)
  );

  assign out_vld = stage_vld[LAT-1];

  // Count of valid sets between input and output, for alignment checks.
  localparam int FW = $clog2(LAT + 1) + 1;
  logic [FW-1:0] flight;
  logic [FW-1:0] nxt_flight;

  always_comb nxt_flight = flight + FW'(in_vld) - FW'(out_vld);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flight <= '0;
    else        flight <= nxt_flight;
  end

  p_flight_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flight <= FW'(LAT));

  p_out_has_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (flight != '0));
endmodule

// File: tb/csat_tree_bench.sv
module csat_tree_bench;
  localparam int N      = 8;
  localparam int W      = 16;
  localparam int SW     = W + $clog2(N);
  localparam int LAT    = 5;
  localparam int CLK_NS = 10;
  localparam int NVEC   = 6;

  localparam logic signed [W-1:0] VEC [NVEC][N] = '{
    '{16'sd1, 16'sd2, 16'sd3, 16'sd4, 16'sd5, 16'sd6, 16'sd7, 16'sd8},
    '{-16'sd1, -16'sd1, -16'sd1, -16'sd1, -16'sd1, -16'sd1, -16'sd1, -16'sd1},
    '{16'sd32767, -16'sd32768, 16'sd32767, -16'sd32768, 16'sd100, -16'sd5, 16'sd0, 16'sd9},
    '{16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0},
    '{16'sd1000, -16'sd2000, 16'sd3000, -16'sd4000, 16'sd5000, -16'sd6000, 16'sd7000, -16'sd8000},
    '{16'sd12345, -16'sd321, 16'sd12345, -16'sd321, 16'sd12345, -16'sd321, 16'sd12345, -16'sd321}
  };

  logic          clk;
  logic          rst_n;
  logic          in_vld;
  logic [N*W-1:0] in_ops;
  logic          out_vld;
  logic [SW-1:0] out_sum;

  int total_chk;
  int bad_chk;
  string cur_tag;
  bit mon_on;

  logic [SW-1:0] exp_q [64];
  int wr_idx;
  int rd_idx;
  logic [LAT-1:0] hist;
  logic [SW-1:0] last_exp;

  csat_tree #(.N(N), .W(W)) u_csat_tree (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .in_ops  (in_ops),
    .out_vld (out_vld),
    .out_sum (out_sum)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [SW-1:0] ref_sum(input logic [N*W-1:0] ops);
    int acc;
    acc = 0;
    for (int i = 0; i < N; i++) acc = acc + int'($signed(ops[i*W +: W]));
    return SW'(acc);
  endfunction

  task automatic check(input string req, input logic [SW-1:0] act, input logic [SW-1:0] exp);
    total_chk++;
    if (act !== exp) begin
      bad_chk++;
      $display("FAIL %s actual=%0d expected=%0d", req, $signed(act), $signed(exp));
    end
  endtask

  // Reference: valid history and queue of expected totals.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist   <= '0;
      wr_idx <= 0;
    end else begin
      hist <= {hist[LAT-2:0], in_vld};
      if (in_vld) begin
        exp_q[wr_idx % 64] <= ref_sum(in_ops);
        wr_idx <= wr_idx + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      rd_idx = 0;
    end else if (mon_on) begin
      check({"R5 valid delay ", cur_tag}, SW'(out_vld), SW'(hist[LAT-1]));
      if (out_vld) begin
        check({"R1 ", cur_tag}, out_sum, exp_q[rd_idx % 64]);
        last_exp = exp_q[rd_idx % 64];
        rd_idx = rd_idx + 1;
      end
    end
  end

  task automatic drive(input logic v, input logic [N*W-1:0] ops);
    @(negedge clk);
    in_vld = v;
    in_ops = ops;
  endtask

  function automatic logic [N*W-1:0] all_lanes(input logic [W-1:0] x);
    logic [N*W-1:0] r;
    for (int i = 0; i < N; i++) r[i*W +: W] = x;
    return r;
  endfunction

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad_chk++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [N*W-1:0] ops;
    logic [SW-1:0] held;
    total_chk = 0;
    bad_chk   = 0;
    mon_on    = 1'b0;
    cur_tag   = "reset";
    rst_n     = 1'b0;
    in_vld    = 1'b0;
    in_ops    = '0;
    last_exp  = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 reset out_vld", SW'(out_vld), '0);
    check("R8 reset out_sum", out_sum, '0);
    rst_n  = 1'b1;
    mon_on = 1'b1;

    // R1, R7: table walked back to back
    cur_tag = "table R7";
    for (int k = 0; k < NVEC; k++) begin
      for (int i = 0; i < N; i++) ops[i*W +: W] = VEC[k][i];
      drive(1'b1, ops);
    end
    drive(1'b0, '0);
    repeat (LAT + 2) @(negedge clk);
    check("R7 all table results seen", SW'(rd_idx), SW'(NVEC));

    // R3: extremes
    cur_tag = "R3 extremes";
    drive(1'b1, all_lanes(16'h8000));
    drive(1'b1, all_lanes(16'h7fff));
    drive(1'b0, '0);
    repeat (LAT + 1) @(negedge clk);
    check("R3 max positive total", last_exp, SW'(262136));

    // R4: output holds while idle, inputs noisy
    held = out_sum;
    for (int k = 0; k < 8; k++) begin
      drive(1'b0, {N{16'h5a5a ^ 16'(k * 977)}});
      check("R4 hold while idle", out_sum, held);
    end
    @(negedge clk);
    check("R4 hold equals last result", out_sum, SW'(262136));

    // R6: leftover lanes only
    cur_tag = "R6 leftover";
    ops = '0;
    ops[7*W +: W] = 16'sd1234;
    drive(1'b1, ops);
    ops = '0;
    ops[6*W +: W] = -16'sd77;
    drive(1'b1, ops);
    drive(1'b0, '0);
    repeat (LAT) @(negedge clk);
    check("R6 last leftover value", last_exp, SW'(-77));

    // R3: most negative total checked by value
    cur_tag = "R3 negative";
    drive(1'b1, all_lanes(16'h8000));
    drive(1'b0, '0);
    repeat (LAT) @(negedge clk);
    check("R3 most negative total", last_exp, SW'(-262144));

    // R8: asynchronous reset with sets in flight
    cur_tag = "R8 midstream";
    drive(1'b1, all_lanes(16'h0011));
    drive(1'b1, all_lanes(16'h0022));
    drive(1'b1, all_lanes(16'h0033));
    repeat (LAT - 2) @(negedge clk);
    mon_on = 1'b0;
    #1 rst_n = 1'b0;
    #1;
    check("R8 midstream out_vld", SW'(out_vld), '0);
    check("R8 midstream out_sum", out_sum, '0);
    in_vld = 1'b0;
    repeat (2) @(negedge clk);
    rst_n  = 1'b1;
    mon_on = 1'b1;
    repeat (LAT + 1) @(negedge clk);
    check("R8 no stale result after reset", SW'(rd_idx), '0);

    // R1, R7: one more burst after reset
    cur_tag = "post reset";
    drive(1'b1, all_lanes(16'h0003));
    drive(1'b1, all_lanes(16'hfffd));
    drive(1'b0, '0);
    repeat (LAT + 1) @(negedge clk);
    check("R7 post reset results seen", SW'(rd_idx), SW'(2));
    finish_run();
  end
endmodule